// File: doc/BRIEF.md
# Serial Real-Time-Clock Register Interface

This block is the serial slave front end of a real-time-clock register file. A host talks to it over a four-wire serial link with an active-high chip select. Every transaction opens with one command byte: its top bit picks the direction and its low seven bits pick the first register. Each byte that follows is written to or read from the next register in turn. The burst runs until chip select falls, so one command byte is enough to fetch the whole date and time.

The storage is split into regions: seven time bytes, two four-byte alarm sets, a system group of control, status and trickle configuration, an unmapped gap, and a 96-byte general-purpose RAM. A write-protect flag in the control byte locks every register except the control byte itself against serial writes. The timekeeping and alarm logic reach the same storage through a plain parallel read/write port. That port is not subject to write protection.

The serial pins are synchronised into the system clock domain and their edges are detected there. The serial clock must therefore be much slower than the system clock. The serial clock idles low. MOSI is sampled on the falling edge and MISO changes on the rising edge.

Top module: `spi_rtc_regif`

## Requirements
- R1: After reset the control byte (address 0x0F) reads 0x80 and every other register reads 0x00; MISO is low.
- R2: A command byte with bit 7 set starts a write burst at the address in bits 6:0. Each following complete byte is stored at the current address.
- R3: A command byte with bit 7 clear starts a read burst. Bits travel MSB first. MOSI is sampled on falling serial-clock edges. MISO presents the first bit of each data byte from the first rising edge after the preceding byte.
- R4: Within one burst the address advances by one per byte, so seven consecutive time bytes are read after a single command byte.
- R5: The address wraps inside its region during a burst. Time 0x06→0x00, alarm sets 0x0A→0x07 and 0x0E→0x0B, system group 0x11→0x0F, gap 0x1F→0x12, RAM 0x7F→0x20.
- R6: Addresses 0x12–0x1F hold no register. Reads there return 0x00 and writes there are discarded.
- R7: While control bit 6 is set, serial writes to every address other than 0x0F are discarded. Writes to 0x0F still take effect.
- R8: Control bits 5:3 and status (0x10) bits 7:2 always read 0. Control bit 7 and the trickle byte (0x11) are stored as written.
- R9: Chip select falling before the eighth bit of a byte discards that byte. The next transaction starts again with a command byte.
- R10: The parallel port reads combinationally and writes on the next clock edge. Its writes are not blocked by write protection, and they become visible to serial reads.
- R11: MISO stays low while chip select is inactive, during the command byte, and during write bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| spi_cs_i | input | 1 | Chip select, active high |
| spi_sclk_i | input | 1 | Serial clock, idles low |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| core_we_i | input | 1 | Parallel-port write strobe |
| core_addr_i | input | 7 | Parallel-port register address |
| core_wdata_i | input | 8 | Parallel-port write data |
| core_rdata_o | output | 8 | Parallel-port read data |

## Verification
The hardest case to reach from the pins is a byte cut short by chip select. The shift register then holds part of a byte that must leave no trace, and the next command byte must still parse cleanly. The stimulus starts a write to RAM, stops after five data bits, and reads the location back through the parallel port. It also cuts a command byte off after three bits and then runs a normal read. Wrap at the region ends is reached by bursts that start one or two bytes before each region's last address.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;

    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 8;
    localparam int NUM_LOC  = 1 << ADDR_W;
    localparam int RAM_LEN  = 96;
    localparam int CNT_W    = $clog2(DATA_W);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t TIME_LO  = 7'h00;
    localparam addr_t TIME_HI  = 7'h06;
    localparam addr_t ALMA_LO  = 7'h07;
    localparam addr_t ALMA_HI  = 7'h0A;
    localparam addr_t ALMB_LO  = 7'h0B;
    localparam addr_t ALMB_HI  = 7'h0E;
    localparam addr_t CTRL_ADR = 7'h0F;
    localparam addr_t STAT_ADR = 7'h10;
    localparam addr_t TRKL_ADR = 7'h11;
    localparam addr_t GAP_LO   = 7'h12;
    localparam addr_t GAP_HI   = 7'h1F;
    localparam addr_t RAM_LO   = 7'h20;
    localparam addr_t RAM_HI   = addr_t'(int'(RAM_LO) + RAM_LEN - 1);

    localparam int    WP_BIT    = 6;
    localparam byte_t CTRL_MASK = 8'hC7;
    localparam byte_t STAT_MASK = 8'h03;
    localparam byte_t CTRL_INIT = 8'h80;

    typedef enum logic { PH_CMD = 1'b0, PH_DATA = 1'b1 } phase_t;

    typedef struct packed {
        addr_t lo;
        addr_t hi;
        logic  mapped;
    } region_t;

    function automatic region_t region_of(addr_t a);
        region_t r;
        r.mapped = 1'b1;
        if (a <= TIME_HI) begin
            r.lo = TIME_LO; r.hi = TIME_HI;
        end else if (a <= ALMA_HI) begin
            r.lo = ALMA_LO; r.hi = ALMA_HI;
        end else if (a <= ALMB_HI) begin
            r.lo = ALMB_LO; r.hi = ALMB_HI;
        end else if (a <= TRKL_ADR) begin
            r.lo = CTRL_ADR; r.hi = TRKL_ADR;
        end else if (a < RAM_LO) begin
            r.lo = GAP_LO; r.hi = GAP_HI; r.mapped = 1'b0;
        end else begin
            r.lo = RAM_LO; r.hi = RAM_HI;
        end
        return r;
    endfunction

    function automatic addr_t next_addr(addr_t a);
        region_t r;
        r = region_of(a);
        return (a == r.hi) ? r.lo : addr_t'(a + 1'b1);
    endfunction

    function automatic byte_t keep_mask(addr_t a);
        if (a == CTRL_ADR) return CTRL_MASK;
        if (a == STAT_ADR) return STAT_MASK;
        return '1;
    endfunction

endpackage

// File: rtl/spi_rtc_sync.sv
module spi_rtc_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i)       stage_q[s] <= '0;
            else if (s == 0) stage_q[s] <= d_i;
            else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rtc_shifter.sv
module spi_rtc_shifter
    import spi_rtc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cs_s_i,
    input  logic             sclk_s_i,
    input  logic             mosi_s_i,
    input  logic             load_i,
    input  byte_t            load_byte_i,
    output logic             byte_done_o,
    output byte_t            rx_byte_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic             miso_o
);
    logic             sclk_q;
    logic             rise, fall;
    logic [CNT_W-1:0] cnt_q;
    byte_t            rx_q, tx_q;
    logic             miso_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) sclk_q <= 1'b0;
        else       sclk_q <= sclk_s_i;
    end

    assign rise = cs_s_i &  sclk_s_i & ~sclk_q;
    assign fall = cs_s_i & ~sclk_s_i &  sclk_q;

    assign byte_done_o = fall && (cnt_q == CNT_W'(DATA_W - 1));
    assign rx_byte_o   = {rx_q[DATA_W-2:0], mosi_s_i};

    always_ff @(posedge clk_i) begin
        if (rst_i || !cs_s_i) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            miso_q <= 1'b0;
        end else begin
            if (fall) begin
                cnt_q <= cnt_q + 1'b1;
                rx_q  <= rx_byte_o;
            end
            if (load_i) begin
                tx_q <= load_byte_i;
            end else if (rise) begin
                miso_q <= tx_q[DATA_W-1];
                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign bit_cnt_o = cnt_q;
    assign miso_o    = miso_q;
endmodule

// File: rtl/spi_rtc_regs.sv
module spi_rtc_regs
    import spi_rtc_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_i,
    input  logic  spi_we_i,
    input  addr_t spi_waddr_i,
    input  byte_t spi_wdata_i,
    input  addr_t spi_raddr_i,
    output byte_t spi_rdata_o,
    input  logic  core_we_i,
    input  addr_t core_addr_i,
    input  byte_t core_wdata_i,
    output byte_t core_rdata_o,
    output byte_t ctrl_o,
    output byte_t stat_o
);
    byte_t store_q [NUM_LOC];
    logic  wp;
    logic  spi_ok, core_ok;

    assign wp      = store_q[CTRL_ADR][WP_BIT];
    assign spi_ok  = spi_we_i && region_of(spi_waddr_i).mapped
                     && (!wp || spi_waddr_i == CTRL_ADR);
    assign core_ok = core_we_i && region_of(core_addr_i).mapped;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < NUM_LOC; i++)
                store_q[i] <= (i == int'(CTRL_ADR)) ? CTRL_INIT : '0;
        end else begin
            if (spi_ok)
                store_q[spi_waddr_i] <= spi_wdata_i & keep_mask(spi_waddr_i);
            if (core_ok)
                store_q[core_addr_i] <= core_wdata_i & keep_mask(core_addr_i);
        end
    end

    assign spi_rdata_o  = region_of(spi_raddr_i).mapped ? store_q[spi_raddr_i] : '0;
    assign core_rdata_o = region_of(core_addr_i).mapped ? store_q[core_addr_i] : '0;
    assign ctrl_o       = store_q[CTRL_ADR];
    assign stat_o       = store_q[STAT_ADR];
endmodule

// File: rtl/spi_rtc_regif.sv
module spi_rtc_regif
    import spi_rtc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       spi_cs_i,
    input  logic       spi_sclk_i,
    input  logic       spi_mosi_i,
    output logic       spi_miso_o,
    input  logic       core_we_i,
    input  logic [6:0] core_addr_i,
    input  logic [7:0] core_wdata_i,
    output logic [7:0] core_rdata_o
);
    logic [2:0]       pins_s;
    logic             cs_s, sclk_s, mosi_s;
    logic             byte_done;
    byte_t            rx_byte;
    logic [CNT_W-1:0] bit_cnt;
    phase_t           phase_q;
    logic             wr_q;
    addr_t            ptr_q;
    addr_t            rd_addr;
    byte_t            rd_data;
    logic             spi_we, tx_load;
    byte_t            ctrl_v, stat_v;

    spi_rtc_sync #(.W(3), .STAGES(2)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({spi_cs_i, spi_sclk_i, spi_mosi_i}),
        .q_o   (pins_s)
    );
    assign {cs_s, sclk_s, mosi_s} = pins_s;

    assign rd_addr = (phase_q == PH_CMD) ? rx_byte[ADDR_W-1:0] : next_addr(ptr_q);
    assign spi_we  = byte_done && (phase_q == PH_DATA) && wr_q;
    assign tx_load = byte_done && ((phase_q == PH_CMD) ? !rx_byte[DATA_W-1] : !wr_q);

    spi_rtc_shifter u_shift (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cs_s_i      (cs_s),
        .sclk_s_i    (sclk_s),
        .mosi_s_i    (mosi_s),
        .load_i      (tx_load),
        .load_byte_i (rd_data),
        .byte_done_o (byte_done),
        .rx_byte_o   (rx_byte),
        .bit_cnt_o   (bit_cnt),
        .miso_o      (spi_miso_o)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i || !cs_s) begin
            phase_q <= PH_CMD;
            wr_q    <= 1'b0;
            ptr_q   <= '0;
        end else if (byte_done) begin
            if (phase_q == PH_CMD) begin
                phase_q <= PH_DATA;
                wr_q    <= rx_byte[DATA_W-1];
                ptr_q   <= rx_byte[ADDR_W-1:0];
            end else begin
                ptr_q   <= next_addr(ptr_q);
            end
        end
    end

    spi_rtc_regs u_regs (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .spi_we_i     (spi_we),
        .spi_waddr_i  (ptr_q),
        .spi_wdata_i  (rx_byte),
        .spi_raddr_i  (rd_addr),
        .spi_rdata_o  (rd_data),
        .core_we_i    (core_we_i),
        .core_addr_i  (core_addr_i),
        .core_wdata_i (core_wdata_i),
        .core_rdata_o (core_rdata_o),
        .ctrl_o       (ctrl_v),
        .stat_o       (stat_v)
    );
endmodule

// File: rtl/spi_rtc_regif_chk.sv
module spi_rtc_regif_chk
    import spi_rtc_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             cs_s,
    input logic             miso,
    input phase_t           phase,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             byte_done,
    input addr_t            ptr,
    input byte_t            ctrl,
    input byte_t            stat,
    input byte_t            time0,
    input byte_t            ram0,
    input logic             core_we,
    input addr_t            core_addr,
    input byte_t            core_wdata
);
    a_r8_ctrl_rsvd: assert property (@(posedge clk_i) disable iff (rst_i)
        ctrl[5:3] == 3'b000);

    a_r8_stat_rsvd: assert property (@(posedge clk_i) disable iff (rst_i)
        stat[7:2] == 6'b0);

    a_r9_abort_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        !cs_s |=> (bit_cnt == '0 && phase == PH_CMD));

    a_r11_miso_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        !cs_s |=> !miso);

    a_r5_ram_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (byte_done && phase == PH_DATA && ptr == RAM_HI) |=> ptr == RAM_LO);

    a_r7_wp_holds_time: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl[WP_BIT] && !(core_we && core_addr == TIME_LO)) |=> $stable(time0));

    a_r10_core_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (core_we && core_addr == RAM_LO) |=> ram0 == $past(core_wdata));
endmodule

bind spi_rtc_regif spi_rtc_regif_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cs_s       (cs_s),
    .miso       (spi_miso_o),
    .phase      (phase_q),
    .bit_cnt    (bit_cnt),
    .byte_done  (byte_done),
    .ptr        (ptr_q),
    .ctrl       (ctrl_v),
    .stat       (stat_v),
    .time0      (u_regs.store_q[0]),
    .ram0       (u_regs.store_q[32]),
    .core_we    (core_we_i),
    .core_addr  (core_addr_i),
    .core_wdata (core_wdata_i)
);

// File: tb/spi_rtc_regif_tb.sv
module spi_rtc_regif_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, sclk = 1'b0, mosi = 1'b0;
    logic       miso;
    logic       core_we = 1'b0;
    logic [6:0] core_addr = '0;
    logic [7:0] core_wdata = '0;
    logic [7:0] core_rdata;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] wq[$];
    logic [7:0] rq[$];

    always #5 clk = ~clk;

    spi_rtc_regif u_dut (
        .clk_i        (clk),
        .rst_i        (rst),
        .spi_cs_i     (cs),
        .spi_sclk_i   (sclk),
        .spi_mosi_i   (mosi),
        .spi_miso_o   (miso),
        .core_we_i    (core_we),
        .core_addr_i  (core_addr),
        .core_wdata_i (core_wdata),
        .core_rdata_o (core_rdata)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic spi_begin();
        @(negedge clk);
        cs = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic spi_end();
        repeat (4) @(negedge clk);
        cs = 1'b0;
        mosi = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sclk = 1'b1;
            mosi = b[i];
            repeat (25) @(negedge clk);
            sclk = 1'b0;
            repeat (25) @(negedge clk);
        end
    endtask

    // write burst: bytes staged in wq
    task automatic spi_wr(input logic [6:0] a);
        spi_begin();
        send_bits({1'b1, a}, 8);
        foreach (wq[i]) send_bits(wq[i], 8);
        spi_end();
    endtask

    // read burst: expected bytes staged in rq, handed to the monitor
    task automatic spi_rd(input logic [6:0] a, input string tag);
        foreach (rq[i]) begin
            exp_q.push_back(rq[i]);
            tag_q.push_back(tag);
        end
        spi_begin();
        send_bits({1'b0, a}, 8);
        foreach (rq[i]) send_bits(8'h00, 8);
        spi_end();
    endtask

    task automatic core_rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        core_addr = a;
        #1;
        chk(core_rdata, exp, tag);
    endtask

    task automatic core_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        core_we = 1'b1;
        core_addr = a;
        core_wdata = d;
        @(negedge clk);
        core_we = 1'b0;
    endtask

    // monitor: rebuilds bytes at the host's sample edge and scores them
    initial begin
        forever begin
            int         nbit, nbyte;
            logic       is_wr;
            logic [7:0] mi, mo;
            @(posedge cs);
            nbit = 0; nbyte = 0; is_wr = 1'b0; mi = '0; mo = '0;
            while (cs) begin
                @(negedge sclk or negedge cs);
                if (!cs) break;
                mi = {mi[6:0], mosi};
                mo = {mo[6:0], miso};
                nbit++;
                if (nbit == 8) begin
                    nbit = 0;
                    if (nbyte == 0) begin
                        is_wr = mi[7];
                        chk(mo, 8'h00, "R11 miso during command byte");
                    end else if (is_wr) begin
                        chk(mo, 8'h00, "R11 miso during write burst");
                    end else if (exp_q.size() == 0) begin
                        chk(mo, 8'hxx, "R3 unexpected read byte");
                    end else begin
                        chk(mo, exp_q.pop_front(), tag_q.pop_front());
                    end
                    nbyte++;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk({7'b0, miso}, 8'h00, "R1 miso after reset");
        core_rd(7'h0F, 8'h80, "R1 control reset");
        core_rd(7'h00, 8'h00, "R1 time reset");
        core_rd(7'h20, 8'h00, "R1 ram reset");
        rq = '{8'h80, 8'h00, 8'h00};
        spi_rd(7'h0F, "R1 system group via serial");

        // R2 write burst of time bytes, R4 single-command burst read
        wq = '{8'h59, 8'h01, 8'h80, 8'h03, 8'h31, 8'h12, 8'h99};
        spi_wr(7'h00);
        core_rd(7'h03, 8'h03, "R2 time byte 3 stored");
        core_rd(7'h06, 8'h99, "R2 time byte 6 stored");
        rq = '{8'h59, 8'h01, 8'h80, 8'h03, 8'h31, 8'h12, 8'h99};
        spi_rd(7'h00, "R4 seven-byte time burst");

        // R3 MSB-first with asymmetric patterns in an alarm set
        wq = '{8'h01, 8'h80, 8'hC3};
        spi_wr(7'h07);
        rq = '{8'h01, 8'h80, 8'hC3};
        spi_rd(7'h07, "R3 bit order");

        // R5 wrap in time, RAM and alarm regions
        rq = '{8'h12, 8'h99, 8'h59, 8'h01};
        spi_rd(7'h05, "R5 time wrap");
        wq = '{8'hA1, 8'hA2, 8'hA3};
        spi_wr(7'h7E);
        core_rd(7'h20, 8'hA3, "R5 ram write wrapped to base");
        core_rd(7'h21, 8'h00, "R5 ram wrap stops at base");
        rq = '{8'hA1, 8'hA2, 8'hA3};
        spi_rd(7'h7E, "R5 ram read wrap");
        wq = '{8'h44, 8'h55};
        spi_wr(7'h0E);
        core_rd(7'h0B, 8'h55, "R5 alarm set wrap");

        // R8 reserved bits and system-group wrap
        wq = '{8'h3F, 8'hFF, 8'hA9};
        spi_wr(7'h0F);
        rq = '{8'h07, 8'h03, 8'hA9};
        spi_rd(7'h0F, "R8 reserved bits read zero");
        rq = '{8'hA9, 8'h07};
        spi_rd(7'h11, "R5 system group wrap");

        // R6 unmapped gap
        wq = '{8'h5A};
        spi_wr(7'h15);
        core_rd(7'h15, 8'h00, "R6 gap write discarded");
        rq = '{8'h00, 8'h00, 8'h00};
        spi_rd(7'h1E, "R6 gap reads zero");

        // R7 write protection
        wq = '{8'h40};
        spi_wr(7'h0F);
        core_rd(7'h0F, 8'h40, "R7 protect bit set");
        wq = '{8'h77};
        spi_wr(7'h00);
        core_rd(7'h00, 8'h59, "R7 time write blocked");
        wq = '{8'h77};
        spi_wr(7'h30);
        core_rd(7'h30, 8'h00, "R7 ram write blocked");

        // R10 parallel port ignores protection, visible to serial reads
        core_wr(7'h31, 8'hC3);
        core_rd(7'h31, 8'hC3, "R10 core write under protection");
        rq = '{8'hC3};
        spi_rd(7'h31, "R10 core write seen by serial read");

        // R7 control still writable, then writes resume
        wq = '{8'h00};
        spi_wr(7'h0F);
        core_rd(7'h0F, 8'h00, "R7 control write under protection");
        wq = '{8'h77};
        spi_wr(7'h30);
        core_rd(7'h30, 8'h77, "R7 write after unprotect");

        // R9 abort mid data byte and mid command byte
        spi_begin();
        send_bits(8'hA0, 8);
        send_bits(8'h5A, 5);
        spi_end();
        core_rd(7'h20, 8'hA3, "R9 partial data byte discarded");
        spi_begin();
        send_bits(8'h80, 3);
        spi_end();
        rq = '{8'h01, 8'h80};
        spi_rd(7'h01, "R9 fresh command after abort");
        chk({7'b0, miso}, 8'h00, "R11 miso with chip select low");

        repeat (20) @(negedge clk);
        chk(8'(exp_q.size()), 8'h00, "R3 all expected reads seen");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule